// File: doc/BRIEF.md
# Prioritised ADC Sample Sequencer

This block schedules conversions on one shared analog-to-digital converter for four sample sequencers. Each sequencer has an enable bit, a selectable trigger source, a two-bit priority and a short step program. Sequencer 0 holds up to 8 steps, sequencers 1 and 2 hold up to 4 steps each, and sequencer 3 holds 1 step. A trigger is latched as a pending request. When the converter is free, the enabled pending sequencer with the best priority is granted. It then walks its steps in order and issues one conversion request per step. Each request carries the channel, a differential flag and a temperature-sensor flag.

The converter is external to the block. It is modelled as a request/done handshake. Every result comes back on a result strobe tagged with the sequencer number. A step can pulse that sequencer's interrupt line when its conversion completes. Software configures the block through a simple write port.

The control path is a two-state machine:
- `ST_IDLE` arbitrates among the pending sequencers. The transition grant (`ST_IDLE` to `ST_CONVERT`) fires when any request is pending.
- `ST_CONVERT` holds the request high until `conv_done` arrives. The transition advance (`ST_CONVERT` to `ST_CONVERT`, step plus one) fires on done when the step is not the last. The transition finish (`ST_CONVERT` to `ST_IDLE`) fires on done when the step is the last.

Top module: `adc_seq_sched`

## Requirements
- R1: After reset, `conv_req`, `res_valid` and `irq` are low, and every sequencer is disabled.
- R2: The configuration registers and their fields are:

  | Address | Contents |
  |---|---|
  | 0 | Enable bits, one per sequencer at bit n |
  | 1 | Trigger selects, 4 bits per sequencer at bit 4n |
  | 2 | Priorities, 2 bits per sequencer at bit 4n |
  | 8+n | Channel field of each step of sequencer n, 4 bits at bit 4×step |
  | 12+n | Control nibble of each step of sequencer n, 4 bits at bit 4×step |

  Control nibble bits: bit0 differential, bit1 end, bit2 interrupt enable, bit3 temperature sensor.
- R3: Trigger code 0 selects the sequencer's own bit of `sw_trig`. Codes 1 to 8 select `hw_evt[code-1]`. Code 15 is "always". Any other code never fires. An event on a source that is not selected has no effect.
- R4: A disabled sequencer ignores its triggers and never runs.
- R5: In `ST_IDLE`, the pending sequencer with the lowest priority value is granted. A tie goes to the lower sequencer number. The first request rises one cycle after the trigger is latched.
- R6: A running sequence is never interrupted. A higher-priority trigger waits until the last step of the running sequence has completed.
- R7: Steps run from step 0 upward. `conv_req` and the step's fields stay stable until `conv_done`, and the next step's request follows in the next cycle.
- R8: A sequence ends after the step whose end bit is set. If no end bit is set, it ends after the sequencer's highest step (7, 3, 3, 0).
- R9: A single-ended step drives `conv_pos` = channel and `conv_neg` = 0. A differential step with code k drives `conv_pos` = 2k and `conv_neg` = 2k+1. `conv_temp` follows the temperature bit.
- R10: `res_valid` is high in exactly the cycle `conv_done` answers a request. It carries `conv_data` on `res_data` and the running sequencer on `res_seq`.
- R11: A step with interrupt enable set pulses only `irq[n]` of its sequencer, in its result cycle. No other step raises an interrupt.
- R12: A sequencer set to "always" re-runs back to back. Another pending sequencer with a better priority is granted first at the next sequence boundary.
- R13: Any number of triggers that arrive while a sequencer is pending or running are latched as one further run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| sw_trig | input | 4 | Processor trigger strobes, one per sequencer |
| hw_evt | input | 8 | Hardware event strobes for trigger codes 1 to 8 |
| conv_req | output | 1 | Conversion request, held until done |
| conv_pos | output | 5 | Positive (or only) input channel |
| conv_neg | output | 5 | Negative input channel for differential steps |
| conv_diff | output | 1 | Differential conversion |
| conv_temp | output | 1 | Sample the temperature sensor |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 12 | Conversion result |
| res_valid | output | 1 | Result strobe |
| res_seq | output | 2 | Sequencer that produced the result |
| res_data | output | 12 | Forwarded result |
| irq | output | 4 | Per-sequencer step-complete interrupt pulses |

## Verification
A wrong step counter shows at the ports at once as a wrong channel or flag on the next request. A wrong end decision shows as an extra request, or a missing one, one cycle after the last `conv_done`. A wrong sequencer register appears as a wrong `res_seq` on the first result. It can also appear as a second sequencer breaking into a run at the very next step boundary. A corrupted pending latch shows as a missing run, a duplicated run or a run of a disabled sequencer, within two cycles of the trigger or of the end of the current sequence. The directed scenarios place each of these observations at the exact cycle where it must appear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CONVERT = 1'b1
    } seq_state_e;

    // control nibble bit positions
    localparam int CTL_DIFF = 0;
    localparam int CTL_END  = 1;
    localparam int CTL_IE   = 2;
    localparam int CTL_TEMP = 3;

    // trigger codes
    localparam logic [3:0] TRIG_SW     = 4'd0;
    localparam logic [3:0] TRIG_ALWAYS = 4'd15;

    // configuration addresses
    localparam int A_EN      = 0;
    localparam int A_TSEL    = 1;
    localparam int A_PRI     = 2;
    localparam int MUX_BASE  = 8;
    localparam int CTL_BASE  = 12;

    localparam int MAX_STEPS = 8;

    // step capacity of sequencer n
    function automatic int seq_cap(input int n, input int nseq);
        if (n == 0)
            return 8;
        else if (n == nseq - 1)
            return 1;
        else
            return 4;
    endfunction

endpackage

// File: rtl/adc_trig_latch.sv
module adc_trig_latch #(
    parameter int NSEQ = 4,
    parameter int NHW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSEQ-1:0]   en,
    input  logic [4*NSEQ-1:0] tsel,
    input  logic [NSEQ-1:0]   sw_trig,
    input  logic [NHW-1:0]    hw_evt,
    input  logic [NSEQ-1:0]   clr,
    output logic [NSEQ-1:0]   pending
);
    import adc_seq_pkg::*;

    logic [NSEQ-1:0] hit;

    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        logic [3:0] code;
        assign code = tsel[4*g +: 4];

        always_comb begin
            hit[g] = 1'b0;
            if (code == TRIG_SW)
                hit[g] = sw_trig[g];
            else if (code == TRIG_ALWAYS)
                hit[g] = 1'b1;
            else
                for (int k = 0; k < NHW; k++)
                    if (code == 4'(k + 1))
                        hit[g] = hw_evt[k];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pending[g] <= 1'b0;
            else
                pending[g] <= en[g] & ((pending[g] & ~clr[g]) | hit[g]);
        end
    end

endmodule

// File: rtl/adc_seq_arbiter.sv
module adc_seq_arbiter #(
    parameter int NSEQ  = 4,
    localparam int SEL_W = $clog2(NSEQ)
) (
    input  logic [NSEQ-1:0]   pending,
    input  logic [4*NSEQ-1:0] pri,
    output logic              any,
    output logic [SEL_W-1:0]  win
);
    logic [1:0] best;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = 2'd3;
        for (int n = 0; n < NSEQ; n++) begin
            if (pending[n] && (!any || pri[4*n +: 2] < best)) begin
                any  = 1'b1;
                best = pri[4*n +: 2];
                win  = SEL_W'(n);
            end
        end
    end

endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched #(
    parameter int NSEQ   = 4,
    parameter int NHW    = 8,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 4,
    parameter int REG_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [REG_W-1:0]         cfg_wdata,
    input  logic [NSEQ-1:0]          sw_trig,
    input  logic [NHW-1:0]           hw_evt,
    output logic                     conv_req,
    output logic [4:0]               conv_pos,
    output logic [4:0]               conv_neg,
    output logic                     conv_diff,
    output logic                     conv_temp,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic                     res_valid,
    output logic [$clog2(NSEQ)-1:0]  res_seq,
    output logic [DATA_W-1:0]        res_data,
    output logic [NSEQ-1:0]          irq
);
    import adc_seq_pkg::*;

    localparam int SEL_W  = $clog2(NSEQ);
    localparam int STEP_W = $clog2(MAX_STEPS);

    // configuration registers
    logic [NSEQ-1:0]   en_q;
    logic [4*NSEQ-1:0] tsel_q;
    logic [4*NSEQ-1:0] pri_q;
    logic [REG_W-1:0]  mux_q [NSEQ];
    logic [REG_W-1:0]  ctl_q [NSEQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            tsel_q <= '0;
            pri_q  <= '0;
            for (int n = 0; n < NSEQ; n++) begin
                mux_q[n] <= '0;
                ctl_q[n] <= '0;
            end
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(A_EN))
                en_q <= cfg_wdata[NSEQ-1:0];
            if (cfg_addr == ADDR_W'(A_TSEL))
                tsel_q <= cfg_wdata[4*NSEQ-1:0];
            if (cfg_addr == ADDR_W'(A_PRI))
                for (int n = 0; n < NSEQ; n++)
                    pri_q[4*n +: 4] <= {2'b00, cfg_wdata[4*n +: 2]};
            for (int n = 0; n < NSEQ; n++) begin
                if (cfg_addr == ADDR_W'(MUX_BASE + n))
                    mux_q[n] <= cfg_wdata;
                if (cfg_addr == ADDR_W'(CTL_BASE + n))
                    ctl_q[n] <= cfg_wdata;
            end
        end
    end

    // trigger latching and arbitration
    logic [NSEQ-1:0]  pending;
    logic [NSEQ-1:0]  clr;
    logic             arb_any;
    logic [SEL_W-1:0] arb_win;
    logic             grant;

    adc_trig_latch #(.NSEQ(NSEQ), .NHW(NHW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .tsel    (tsel_q),
        .sw_trig (sw_trig),
        .hw_evt  (hw_evt),
        .clr     (clr),
        .pending (pending)
    );

    adc_seq_arbiter #(.NSEQ(NSEQ)) u_arb (
        .pending (pending),
        .pri     (pri_q),
        .any     (arb_any),
        .win     (arb_win)
    );

    assign clr = grant ? (NSEQ'(1) << arb_win) : '0;

    // step walking
    seq_state_e        state_q, state_d;
    logic [SEL_W-1:0]  cur_seq, seq_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [STEP_W-1:0] last_step [NSEQ];
    logic [REG_W-1:0]  cur_mux, cur_ctl;
    logic [3:0]        step_chan, step_ctl;
    logic              seq_last;

    for (genvar g = 0; g < NSEQ; g++) begin : g_cap
        assign last_step[g] = STEP_W'(seq_cap(g, NSEQ) - 1);
    end

    assign cur_mux   = mux_q[cur_seq];
    assign cur_ctl   = ctl_q[cur_seq];
    assign step_chan = cur_mux[{step_q, 2'b00} +: 4];
    assign step_ctl  = cur_ctl[{step_q, 2'b00} +: 4];
    assign seq_last  = step_ctl[CTL_END] || (step_q == last_step[cur_seq]);

    always_comb begin
        state_d = state_q;
        seq_d   = cur_seq;
        step_d  = step_q;
        grant   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arb_any) begin
                    state_d = ST_CONVERT;
                    seq_d   = arb_win;
                    step_d  = '0;
                    grant   = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (conv_done) begin
                    if (seq_last)
                        state_d = ST_IDLE;
                    else
                        step_d = step_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_seq <= '0;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_seq <= seq_d;
            step_q  <= step_d;
        end
    end

    // outputs
    always_comb begin
        conv_req  = (state_q == ST_CONVERT);
        conv_diff = step_ctl[CTL_DIFF];
        conv_temp = step_ctl[CTL_TEMP];
        if (step_ctl[CTL_DIFF]) begin
            conv_pos = {step_chan, 1'b0};
            conv_neg = {step_chan, 1'b1};
        end else begin
            conv_pos = {1'b0, step_chan};
            conv_neg = '0;
        end
        res_valid = conv_req && conv_done;
        res_seq   = cur_seq;
        res_data  = conv_data;
        irq       = (res_valid && step_ctl[CTL_IE]) ? (NSEQ'(1) << cur_seq) : '0;
    end

endmodule

// File: rtl/adc_seq_sched_chk.sv
module adc_seq_sched_chk #(
    parameter int NSEQ = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic                    conv_req,
    input logic                    conv_done,
    input logic [4:0]              conv_pos,
    input logic [4:0]              conv_neg,
    input logic                    conv_diff,
    input logic                    conv_temp,
    input logic                    res_valid,
    input logic [$clog2(NSEQ)-1:0] res_seq,
    input logic [NSEQ-1:0]         irq,
    input logic                    seq_last
);

    p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done && !cfg_we) |=>
            (conv_req && $stable(conv_pos) && $stable(conv_neg)
             && $stable(conv_temp) && $stable(res_seq)));

    p_no_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done && !seq_last) |=> (conv_req && $stable(res_seq)));

    p_seq_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done && seq_last) |=> !conv_req);

    p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_diff) |-> (conv_neg == conv_pos + 5'd1 && !conv_pos[0]));

    p_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (conv_req && conv_done));

    p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> (res_valid && $countones(irq) == 1 && irq[res_seq]));

endmodule

bind adc_seq_sched adc_seq_sched_chk #(.NSEQ(NSEQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .conv_pos  (conv_pos),
    .conv_neg  (conv_neg),
    .conv_diff (conv_diff),
    .conv_temp (conv_temp),
    .res_valid (res_valid),
    .res_seq   (res_seq),
    .irq       (irq),
    .seq_last  (seq_last)
);

// File: tb/adc_seq_sched_test.sv
`timescale 1ns/1ps
module adc_seq_sched_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [3:0]  sw_trig;
    logic [7:0]  hw_evt;
    logic        conv_req;
    logic [4:0]  conv_pos;
    logic [4:0]  conv_neg;
    logic        conv_diff;
    logic        conv_temp;
    logic        conv_done;
    logic [11:0] conv_data;
    logic        res_valid;
    logic [1:0]  res_seq;
    logic [11:0] res_data;
    logic [3:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_seq_sched uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sw_trig   (sw_trig),
        .hw_evt    (hw_evt),
        .conv_req  (conv_req),
        .conv_pos  (conv_pos),
        .conv_neg  (conv_neg),
        .conv_diff (conv_diff),
        .conv_temp (conv_temp),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .res_valid (res_valid),
        .res_seq   (res_seq),
        .res_data  (res_data),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        sw_trig = '0; hw_evt = '0; conv_done = 1'b0; conv_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_sw(input logic [3:0] m);
        sw_trig = m;
        @(negedge clk);
        sw_trig = '0;
    endtask

    task automatic pulse_hw(input logic [7:0] m);
        hw_evt = m;
        @(negedge clk);
        hw_evt = '0;
    endtask

    // one converter handshake with field and result checks
    task automatic conv_step(input string req, input int s, input int pos, input int neg,
                             input bit diff, input bit temp, input logic [3:0] irq_exp,
                             input logic [11:0] data);
        int waited = 0;
        while (!conv_req && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check({req, " request"}, 32'(conv_req), 32'd1);
        if (!conv_req) return;
        check({req, " fields"}, 32'({res_seq, conv_pos, conv_neg, conv_diff, conv_temp}),
              32'({2'(s), 5'(pos), 5'(neg), diff, temp}));
        conv_done = 1'b1; conv_data = data;
        #1;
        check({req, " result"}, 32'({res_valid, res_data, irq}), 32'({1'b1, data, irq_exp}));
        @(negedge clk);
        conv_done = 1'b0; conv_data = '0;
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            if (conv_req || res_valid || irq != '0) seen = 1'b1;
            @(negedge clk);
        end
        check(req, 32'(seen), 32'd0);
    endtask

    // sequencer 1: channels 5,2,9 ; step 2 carries end and interrupt enable
    task automatic prog_seq1();
        wr(9, 32'h0000_7925);
        wr(13, 32'h0000_0600);
    endtask

    task automatic run_seq1(input string req);
        conv_step(req, 1, 5, 0, 0, 0, 4'b0000, 12'h151);
        conv_step(req, 1, 2, 0, 0, 0, 4'b0000, 12'h152);
        conv_step(req, 1, 9, 0, 0, 0, 4'b0010, 12'h153);
    endtask

    // sequencer 0: step 0 differential pair code 3, step 1 temperature + end
    task automatic prog_seq0();
        wr(8, 32'h0000_0053);
        wr(12, 32'h0000_00A1);
    endtask

    task automatic run_seq0(input string req);
        conv_step(req, 0, 6, 7, 1, 0, 4'b0000, 12'h0A0);
        conv_step(req, 0, 5, 0, 0, 1, 4'b0000, 12'h0A1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset outputs", 32'({conv_req, res_valid, irq}), 32'd0);
        pulse_sw(4'b1111);
        expect_quiet("R1 R4 all disabled after reset", 6);
    endtask

    task automatic t_steps();
        do_reset();
        prog_seq1();
        wr(0, 32'h2);
        pulse_sw(4'b0010);
        run_seq1("R7 R10 R11 R2 step walk");
        expect_quiet("R8 stop after end bit", 8);
    endtask

    task automatic t_diff();
        do_reset();
        prog_seq0();
        wr(0, 32'h1);
        pulse_sw(4'b0001);
        run_seq0("R9 R2 differential and temperature");
        expect_quiet("R8 end on step 1", 5);
    endtask

    task automatic t_priority();
        do_reset();
        prog_seq0();
        wr(10, 32'h4);
        wr(14, 32'h2);
        wr(2, 32'h3032);
        wr(0, 32'h5);
        pulse_sw(4'b0101);
        conv_step("R5 better priority first", 2, 4, 0, 0, 0, 4'b0000, 12'h244);
        run_seq0("R5 lower priority second");
        expect_quiet("R5 done", 4);
        wr(2, 32'h3131);
        pulse_sw(4'b0101);
        run_seq0("R5 tie lower number first");
        conv_step("R5 tie second", 2, 4, 0, 0, 0, 4'b0000, 12'h245);
        expect_quiet("R5 tie done", 4);
    endtask

    task automatic t_no_preempt();
        do_reset();
        prog_seq0();
        prog_seq1();
        wr(2, 32'h0030);
        wr(0, 32'h3);
        pulse_sw(4'b0010);
        conv_step("R6 low priority step 0", 1, 5, 0, 0, 0, 4'b0000, 12'h300);
        pulse_sw(4'b0001);
        conv_step("R6 still running step 1", 1, 2, 0, 0, 0, 4'b0000, 12'h301);
        conv_step("R6 still running step 2", 1, 9, 0, 0, 0, 4'b0010, 12'h302);
        run_seq0("R6 waiting sequencer after boundary");
        expect_quiet("R6 done", 4);
    endtask

    task automatic t_latch_once();
        do_reset();
        prog_seq1();
        wr(0, 32'h2);
        pulse_sw(4'b0010);
        conv_step("R13 first run", 1, 5, 0, 0, 0, 4'b0000, 12'h400);
        pulse_sw(4'b0010);
        pulse_sw(4'b0010);
        conv_step("R13 first run", 1, 2, 0, 0, 0, 4'b0000, 12'h401);
        conv_step("R13 first run", 1, 9, 0, 0, 0, 4'b0010, 12'h402);
        run_seq1("R13 single repeat");
        expect_quiet("R13 no third run", 8);
    endtask

    task automatic t_disabled();
        do_reset();
        prog_seq1();
        wr(11, 32'hC);
        wr(0, 32'h1);
        pulse_sw(4'b1110);
        expect_quiet("R4 disabled sequencers ignore triggers", 8);
    endtask

    task automatic t_hw_trig();
        do_reset();
        prog_seq1();
        wr(1, 32'h0050);
        wr(0, 32'h2);
        pulse_hw(8'b0000_1000);
        pulse_sw(4'b0010);
        expect_quiet("R3 unselected sources ignored", 6);
        pulse_hw(8'b0001_0000);
        run_seq1("R3 R2 selected hardware source");
        expect_quiet("R3 done", 4);
    endtask

    task automatic t_no_end();
        do_reset();
        wr(10, 32'h8421);
        wr(11, 32'h000C);
        wr(0, 32'hC);
        pulse_sw(4'b0100);
        conv_step("R8 no end bit", 2, 1, 0, 0, 0, 4'b0000, 12'h500);
        conv_step("R8 no end bit", 2, 2, 0, 0, 0, 4'b0000, 12'h501);
        conv_step("R8 no end bit", 2, 4, 0, 0, 0, 4'b0000, 12'h502);
        conv_step("R8 no end bit", 2, 8, 0, 0, 0, 4'b0000, 12'h503);
        expect_quiet("R8 stop at capacity 4", 6);
        pulse_sw(4'b1000);
        conv_step("R8 single step sequencer", 3, 12, 0, 0, 0, 4'b0000, 12'h504);
        expect_quiet("R8 stop at capacity 1", 6);
    endtask

    task automatic t_always();
        do_reset();
        prog_seq0();
        wr(11, 32'h000C);
        wr(15, 32'h0004);
        wr(1, 32'hF000);
        wr(2, 32'h3000);
        wr(0, 32'h9);
        conv_step("R12 always run 1", 3, 12, 0, 0, 0, 4'b1000, 12'h600);
        conv_step("R12 always run 2", 3, 12, 0, 0, 0, 4'b1000, 12'h601);
        pulse_sw(4'b0001);
        conv_step("R12 always run 3", 3, 12, 0, 0, 0, 4'b1000, 12'h602);
        run_seq0("R12 better priority wins boundary");
        conv_step("R12 always resumes", 3, 12, 0, 0, 0, 4'b1000, 12'h603);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_steps();
        t_diff();
        t_priority();
        t_no_preempt();
        t_latch_once();
        t_disabled();
        t_hw_trig();
        t_no_end();
        t_always();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule